// File: doc/BRIEF.md
# DDS Serial Frequency/Phase Loader

This block is the receiving end of the three-wire serial load path of a direct digital synthesizer. Four slow control lines come in from outside the clock domain: a device reset, a serial data line, a word clock and an update strobe. The block samples all four on its own system clock. After a reset it stays in a non-serial state until it sees the entry sequence. It then collects data bits into a 40-bit frame. On every update strobe it copies that frame into the active frequency, phase and power-down register.

The active register drives the synthesizer datapath. Its fields are a 32-bit tuning word, a 5-bit phase offset and a power-down bit. The block also reports whether serial mode is active. A sticky error flag shows that a frame with a nonzero control field was latched. A short-frame flag shows that the last strobe came before a full frame had arrived.

Top module: `dds_serial_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, the tuning word, phase, power-down, error and short-frame outputs are zero and `serial_mode_o` is low.
- R2: A high level on `dds_rst_i` clears the active tuning word, phase and power-down bit. It also clears the error and short-frame flags, empties the frame and bit count, and returns the block to non-serial mode.
- R3: In non-serial mode, one rising edge of `dds_wclk_i` followed by a rising edge of `dds_upd_i` sets `serial_mode_o`. The strobe that completes this entry sequence leaves the active outputs unchanged.
- R4: An update strobe in non-serial mode with no word-clock edge before it leaves the block in non-serial mode.
- R5: In serial mode each word-clock rising edge samples `dds_data_i` and shifts it in at the top, so the first bit of a 40-bit frame ends at bit 0. Frame bits 31:0 are the tuning word, bits 33:32 the control field, bit 34 power-down and bits 39:35 the phase.
- R6: The tuning word, phase and power-down outputs change only on an update strobe in serial mode (or on a reset). Shifting in bits without a strobe leaves them unchanged.
- R7: Each update strobe in serial mode sets the bit count back to zero. A strobe that arrives after fewer than 40 bits still latches the current frame contents and sets `short_frame_o`. A strobe after a full frame clears `short_frame_o`.
- R8: Latching a frame whose control field (bits 33:32) is nonzero sets `ctrl_err_o`. The flag stays set through later clean frames until a reset.
- R9: All four external inputs pass through two-flop synchronizers. The active outputs take a strobe's frame on the third rising clock edge after `dds_upd_i` rises, and not on the second.
- R10: When more than 40 bits arrive before a strobe, the bit count stops at 40 and the last 40 bits received are the ones latched, with no short-frame indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| dds_rst_i | input | 1 | External device reset line, active high |
| dds_data_i | input | 1 | External serial data line |
| dds_wclk_i | input | 1 | External word clock; data is taken on its rising edge |
| dds_upd_i | input | 1 | External update strobe; its rising edge loads the frame |
| tune_word_o | output | 32 | Active frequency tuning word |
| phase_o | output | 5 | Active phase offset |
| pwr_down_o | output | 1 | Active power-down request |
| serial_mode_o | output | 1 | High once the serial entry sequence has been seen |
| ctrl_err_o | output | 1 | Sticky flag: a latched frame had a nonzero control field |
| short_frame_o | output | 1 | The last latched frame had fewer than 40 bits |

## Verification
The loader is driven with several full frames, one set of field values per frame:
- all zeros;
- maximum phase;
- power-down alone;
- a pattern that separates the lowest and highest tuning-word bits;
- a frame with a nonzero control field;
- a clean frame after that one.

Together these show whether bit order, field boundaries and error stickiness are right. An 8-bit short frame and a 48-bit overlong frame separate a counter that resets, saturates and discards the oldest bits from one that wraps or stalls. The strobe latency is sampled one cycle early and on time, which catches a missing or extra synchronizer stage. Strobes in the non-serial state, with and without a word-clock edge first, show that the entry sequence is required and that the entry strobe does not load.

// File: rtl/dds_ser_pkg.sv
package dds_ser_pkg;

  localparam int TW_W    = 32;
  localparam int CTL_W   = 2;
  localparam int PH_W    = 5;
  localparam int FRAME_W = TW_W + CTL_W + 1 + PH_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Input channel indices on the synchronizer bus
  localparam int CH_UPD  = 0;
  localparam int CH_WCLK = 1;
  localparam int CH_DATA = 2;
  localparam int CH_RST  = 3;
  localparam int N_CH    = 4;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ARMED  = 2'd1,
    MODE_SERIAL = 2'd2
  } ld_mode_e;

  // Packed MSB first: phase [39:35], pdn [34], ctl [33:32], tw [31:0]
  typedef struct packed {
    logic [PH_W-1:0]  phase;
    logic             pdn;
    logic [CTL_W-1:0] ctl;
    logic [TW_W-1:0]  tw;
  } dds_frame_t;

endpackage

// File: rtl/dds_in_sync.sv
module dds_in_sync #(
  parameter int            W         = 4,
  parameter int            STAGES    = 2,
  parameter logic [W-1:0]  EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sig_o
);

  for (genvar ch = 0; ch < W; ch++) begin : g_ch
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[ch]};
      end
    end

    if (EDGE_MASK[ch]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else begin
          prev_q <= chain_q[STAGES-1];
        end
      end
      assign sig_o[ch] = chain_q[STAGES-1] & ~prev_q;
    end else begin : g_level
      assign sig_o[ch] = chain_q[STAGES-1];
    end
  end

endmodule

// File: rtl/dds_mode_ctrl.sv
module dds_mode_ctrl
  import dds_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic wclk_rise_i,
  input  logic upd_rise_i,
  output logic serial_o,
  output logic shift_en_o,
  output logic load_en_o
);

  ld_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (clr_i) begin
      mode_d = MODE_IDLE;
    end else begin
      unique case (mode_q)
        MODE_IDLE:   if (wclk_rise_i) mode_d = MODE_ARMED;
        MODE_ARMED:  if (upd_rise_i)  mode_d = MODE_SERIAL;
        MODE_SERIAL: mode_d = MODE_SERIAL;
        default:     mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign serial_o   = (mode_q == MODE_SERIAL);
  // A strobe wins over a coincident word-clock edge
  assign load_en_o  = serial_o && upd_rise_i && !clr_i;
  assign shift_en_o = serial_o && wclk_rise_i && !upd_rise_i && !clr_i;

endmodule

// File: rtl/dds_frame_asm.sv
module dds_frame_asm
  import dds_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_en_i,
  input  logic               bit_i,
  input  logic               load_en_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   cnt_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (load_en_i) begin
      cnt_d = '0;
    end else if (shift_en_i) begin
      sr_d = {bit_i, sr_q[FRAME_W-1:1]};
      if (cnt_q != CNT_FULL) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame_o = sr_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/dds_active_reg.sv
module dds_active_reg
  import dds_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               load_en_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [TW_W-1:0]    tw_o,
  output logic [PH_W-1:0]    phase_o,
  output logic               pdn_o,
  output logic               err_o,
  output logic               short_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  dds_frame_t in_f;
  dds_frame_t act_q, act_d;
  logic       err_q, err_d;
  logic       short_q, short_d;

  assign in_f = dds_frame_t'(frame_i);

  always_comb begin
    act_d   = act_q;
    err_d   = err_q;
    short_d = short_q;
    if (clr_i) begin
      act_d   = '0;
      err_d   = 1'b0;
      short_d = 1'b0;
    end else if (load_en_i) begin
      act_d   = in_f;
      err_d   = err_q | (|in_f.ctl);
      short_d = (cnt_i != CNT_FULL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      err_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      err_q   <= err_d;
      short_q <= short_d;
    end
  end

  assign tw_o    = act_q.tw;
  assign phase_o = act_q.phase;
  assign pdn_o   = act_q.pdn;
  assign err_o   = err_q;
  assign short_o = short_q;

endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
  import dds_ser_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dds_rst_i,
  input  logic            dds_data_i,
  input  logic            dds_wclk_i,
  input  logic            dds_upd_i,
  output logic [TW_W-1:0] tune_word_o,
  output logic [PH_W-1:0] phase_o,
  output logic            pwr_down_o,
  output logic            serial_mode_o,
  output logic            ctrl_err_o,
  output logic            short_frame_o
);

  localparam logic [N_CH-1:0] EDGE_CH = N_CH'((1 << CH_UPD) | (1 << CH_WCLK));

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [N_CH-1:0] raw_in, sync_sig;
  assign raw_in[CH_UPD]  = dds_upd_i;
  assign raw_in[CH_WCLK] = dds_wclk_i;
  assign raw_in[CH_DATA] = dds_data_i;
  assign raw_in[CH_RST]  = dds_rst_i;

  dds_in_sync #(
    .W         (N_CH),
    .STAGES    (2),
    .EDGE_MASK (EDGE_CH)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (raw_in),
    .sig_o   (sync_sig)
  );

  logic ext_clr, data_s, wclk_rise, upd_rise;
  assign ext_clr   = sync_sig[CH_RST];
  assign data_s    = sync_sig[CH_DATA];
  assign wclk_rise = sync_sig[CH_WCLK];
  assign upd_rise  = sync_sig[CH_UPD];

  logic shift_en, load_en;

  dds_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .clr_i       (ext_clr),
    .wclk_rise_i (wclk_rise),
    .upd_rise_i  (upd_rise),
    .serial_o    (serial_mode_o),
    .shift_en_o  (shift_en),
    .load_en_o   (load_en)
  );

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;

  dds_frame_asm u_asm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr_i      (ext_clr),
    .shift_en_i (shift_en),
    .bit_i      (data_s),
    .load_en_i  (load_en),
    .frame_o    (frame),
    .cnt_o      (bit_cnt)
  );

  dds_active_reg u_act (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr_i     (ext_clr),
    .load_en_i (load_en),
    .frame_i   (frame),
    .cnt_i     (bit_cnt),
    .tw_o      (tune_word_o),
    .phase_o   (phase_o),
    .pdn_o     (pwr_down_o),
    .err_o     (ctrl_err_o),
    .short_o   (short_frame_o)
  );

endmodule

// File: rtl/dds_serial_loader_chk.sv
module dds_serial_loader_chk
  import dds_ser_pkg::*;
(
  input logic            clk,
  input logic            rst_n_int,
  input logic            ext_clr,
  input logic            load_en,
  input logic            upd_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [TW_W-1:0] tune_word_o,
  input logic [PH_W-1:0] phase_o,
  input logic            pwr_down_o,
  input logic            serial_mode_o,
  input logic            ctrl_err_o
);

  assert_ext_clear_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ext_clr |=> (tune_word_o == '0 && phase_o == '0 && !pwr_down_o
                 && !serial_mode_o && !ctrl_err_o));

  assert_entry_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(serial_mode_o) |-> $past(upd_rise));

  assert_hold_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!load_en && !ext_clr) |=> ($stable(tune_word_o) && $stable(phase_o) && $stable(pwr_down_o)));

  assert_count_restart_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    load_en |=> (bit_cnt == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl_err_o && !ext_clr) |=> ctrl_err_o);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    bit_cnt <= CNT_W'(FRAME_W));

endmodule

bind dds_serial_loader dds_serial_loader_chk i_chk (
  .clk           (clk),
  .rst_n_int     (rst_n_int),
  .ext_clr       (ext_clr),
  .load_en       (load_en),
  .upd_rise      (upd_rise),
  .bit_cnt       (bit_cnt),
  .tune_word_o   (tune_word_o),
  .phase_o       (phase_o),
  .pwr_down_o    (pwr_down_o),
  .serial_mode_o (serial_mode_o),
  .ctrl_err_o    (ctrl_err_o)
);

// File: tb/test_dds_serial_loader.sv
module test_dds_serial_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // Frame layout (R5): [39:35] phase, [34] power-down, [33:32] control, [31:0] tuning word
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 32'h0000_0000},
    {8'hF8, 32'h1234_5678},
    {8'h04, 32'hFFFF_FFFF},
    {8'h08, 32'h8000_0001},
    {8'h81, 32'hA5A5_5A5A},
    {8'h50, 32'h0F0F_F0F0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dds_rst = 1'b0, dds_data = 1'b0, dds_wclk = 1'b0, dds_upd = 1'b0;
  logic [31:0] tune_word;
  logic [4:0]  phase;
  logic        pwr_down, serial_mode, ctrl_err, short_frame;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench model state
  logic [39:0] m_sr = '0;
  logic [39:0] m_act = '0;
  int          m_cnt = 0;
  bit          m_serial = 1'b0, m_armed = 1'b0, m_err = 1'b0, m_short = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_serial_loader i_dds_serial_loader (
    .clk           (clk),
    .rst_n         (rst_n),
    .dds_rst_i     (dds_rst),
    .dds_data_i    (dds_data),
    .dds_wclk_i    (dds_wclk),
    .dds_upd_i     (dds_upd),
    .tune_word_o   (tune_word),
    .phase_o       (phase),
    .pwr_down_o    (pwr_down),
    .serial_mode_o (serial_mode),
    .ctrl_err_o    (ctrl_err),
    .short_frame_o (short_frame)
  );

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "tune_word", 40'(tune_word), 40'(m_act[31:0]));
    check(req, "phase", 40'(phase), 40'(m_act[39:35]));
    check(req, "pwr_down", 40'(pwr_down), 40'(m_act[34]));
    check(req, "ctrl_err", 40'(ctrl_err), 40'(m_err));
    check(req, "short_frame", 40'(short_frame), 40'(m_short));
    check(req, "serial_mode", 40'(serial_mode), 40'(m_serial));
  endtask

  task automatic wclk_bit(input logic b);
    @(negedge clk);
    dds_data = b;
    dds_wclk = 1'b1;
    repeat (4) @(negedge clk);
    dds_wclk = 1'b0;
    repeat (3) @(negedge clk);
    if (m_serial) begin
      m_sr = {b, m_sr[39:1]};
      if (m_cnt < 40) m_cnt++;
    end else begin
      m_armed = 1'b1;
    end
  endtask

  task automatic send_bits(input logic [39:0] f, input int n);
    for (int i = 0; i < n; i++) wclk_bit(f[i]);
  endtask

  // Strobe with latency probe (R9)
  task automatic strobe();
    logic [39:0] old_act;
    old_act = m_act;
    @(negedge clk);
    dds_upd = 1'b1;
    if (m_serial) begin
      m_act   = m_sr;
      m_err   = m_err | (m_sr[33:32] != 2'b00);
      m_short = (m_cnt != 40);
      m_cnt   = 0;
    end else if (m_armed) begin
      m_serial = 1'b1;
    end
    repeat (2) @(negedge clk);
    check("R9", "tune_word two edges after strobe", 40'(tune_word), 40'(old_act[31:0]));
    @(negedge clk);
    check("R9", "tune_word three edges after strobe", 40'(tune_word), 40'(m_act[31:0]));
    repeat (2) @(negedge clk);
    dds_upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_reset();
    @(negedge clk);
    dds_rst = 1'b1;
    repeat (4) @(negedge clk);
    dds_rst = 1'b0;
    repeat (4) @(negedge clk);
    m_sr = '0; m_act = '0; m_cnt = 0;
    m_serial = 1'b0; m_armed = 1'b0; m_err = 1'b0; m_short = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check_all("R1");          // held in reset
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1");          // after release

    // R4: strobe without a word-clock edge first
    strobe();
    check_all("R4");

    // R3: word-clock edge, then strobe enters serial mode without loading
    wclk_bit(1'b1);
    strobe();
    check_all("R3");

    // Table walk: R5 fields, R6 hold during shifting, R8 sticky error
    for (int v = 0; v < NVEC; v++) begin
      send_bits(VEC[v], 40);
      check_all("R6");
      strobe();
      check_all("R5");
      check("R8", "ctrl_err after frame", 40'(ctrl_err), 40'(m_err));
    end

    // R7: short frame of 8 bits
    send_bits(40'hFF, 8);
    strobe();
    check_all("R7");
    check("R7", "short flag set", 40'(short_frame), 40'd1);

    // R10: 48 bits, last 40 kept
    send_bits(40'hFF, 8);
    send_bits({8'h20, 32'hDEAD_BEEF}, 40);
    strobe();
    check_all("R10");
    check("R10", "tune_word of last 40", 40'(tune_word), 40'hDE_ADBE_EF);
    check("R7", "short flag cleared", 40'(short_frame), 40'd0);

    // R2: external reset clears everything
    ext_reset();
    check_all("R2");
    check("R2", "ctrl_err cleared", 40'(ctrl_err), 40'd0);

    // Re-entry and one more frame after the external reset
    wclk_bit(1'b0);
    strobe();
    check_all("R3");
    send_bits({8'h0C, 32'h0000_1234}, 40);
    strobe();
    check_all("R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule